// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block generates the reset for a processor from three independent causes. The causes are a supply-good flag from an external comparator, an active-low push-button input and an internal watchdog. The processor keeps the watchdog quiet by changing the level on the watchdog input at least once per timeout period. All three inputs are asynchronous. Each passes through a two-flop synchronizer before it is used. The push-button input is also filtered, so that short low glitches are rejected.

Whenever any cause is present, reset is asserted. After the last cause goes away, a recovery counter keeps reset asserted for a fixed number of cycles. The counter restarts every time a cause is seen again. The watchdog counter is held at zero for as long as reset is asserted and starts counting only once reset is released. All timing constants are given in clock cycles. Their defaults are derived from the `TICK_HZ` parameter: 200 ms recovery, 1.6 s timeout and a 250 ns glitch window.

A build parameter selects which inputs exist: both, the push-button only, or the watchdog input only. A second build parameter selects the pad style. With push-pull the pad enable is always on. With open-drain the pad enable is raised only while reset is asserted, so the pin is pulled low and otherwise left to float. The `wd_en_i` pin takes the place of leaving the watchdog input floating.

Top module: `rsup_top`

## Requirements
- R1: While `arst_ni` is low, `rst_no` is 0. After `arst_ni` is released with `supply_ok_i` high, `rst_no` goes to 1 exactly `REC_CYCLES`+2 clock edges later.
- R2: If `supply_ok_i` falls before edge 1, `rst_no` is 0 after edge 3. When the flag returns high before edge 1, `rst_no` is 1 after edge `REC_CYCLES`+2 and not earlier.
- R3: A low on `btn_ni` lasting L ≥ `GLITCH_CYCLES` cycles, applied before edge 1, drives `rst_no` to 0 after edge `GLITCH_CYCLES`+3. Reset is released after edge L+3+`REC_CYCLES`.
- R4: A low on `btn_ni` shorter than `GLITCH_CYCLES` cycles has no effect: `rst_no` stays 1.
- R5: With `wd_en_i` high and no transition on `wdi_i`, the watchdog fires `WD_CYCLES` edges after it last left its cleared state, and `rst_no` falls one edge later.
- R6: Both a rising and a falling level change on `wdi_i` clear the watchdog, including a high pulse only one clock wide. Regular changes spaced closer than `WD_CYCLES` never cause a reset.
- R7: The watchdog never fires while reset is asserted. It counts from zero after release, so a timeout follows `WD_CYCLES`+1 edges after the release edge, however long reset lasted.
- R8: A watchdog expiry is stretched like any other cause: `rst_no` returns to 1 `REC_CYCLES` edges after the last edge at which the expiry was seen.
- R9: With `wd_en_i` low, no watchdog reset is ever produced.
- R10: `rst_o` is at all times the inverse of `rst_no`.
- R11: With `PAD_MODE` = open-drain, `pad_oe_o` is 1 exactly when reset is asserted. With push-pull, `pad_oe_o` is constantly 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock at `TICK_HZ` |
| arst_ni | input | 1 | Asynchronous power-on reset of the logic, active low |
| supply_ok_i | input | 1 | Supply above threshold, from an external comparator, asynchronous |
| btn_ni | input | 1 | Push-button reset request, active low, asynchronous |
| wdi_i | input | 1 | Watchdog service input; any level change services it |
| wd_en_i | input | 1 | Watchdog enable (static configuration) |
| rst_no | output | 1 | Processor reset, active low |
| rst_o | output | 1 | Processor reset, active high |
| pad_oe_o | output | 1 | Output-pad drive enable (open-drain or push-pull style) |

## Verification
Any fault inside this block shows up at the ports as a reset edge that moves, goes missing or appears where none is due. A filter counter that is off by one shows up within a few cycles of a button press: either a pulse of the glitch length is rejected, or one a cycle shorter is accepted. A recovery counter that is wrong moves the release edge by exactly the error. A watchdog that keeps counting during reset, or misses a one-cycle service pulse, fires earlier than `WD_CYCLES`+1 edges after release. The scoreboard therefore pins each expected edge to its exact cycle and also checks the cycle just before it.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  typedef enum logic [1:0] {
    IN_BOTH     = 2'd0,
    IN_BTN_ONLY = 2'd1,
    IN_WDI_ONLY = 2'd2
  } input_set_e;

  typedef enum logic {
    PAD_PUSH_PULL  = 1'b0,
    PAD_OPEN_DRAIN = 1'b1
  } pad_mode_e;

  // Indices into the synchronizer bundle
  localparam int SYN_SUP = 0;
  localparam int SYN_BTN = 1;
  localparam int SYN_WDI = 2;
  localparam int SYN_W   = 3;

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         arst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d_i[i];
        sync_q <= meta_q;
      end
    end
    assign q_o[i] = sync_q;
  end

endmodule

// File: rtl/rsup_btn_filter.sv
module rsup_btn_filter #(
  parameter int GLITCH_CYCLES = 4
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic btn_n_s_i,
  output logic pressed_o
);

  localparam int CW = (GLITCH_CYCLES < 2) ? 1 : $clog2(GLITCH_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYCLES - 1);

  logic [CW-1:0] low_cnt_q;
  logic          pressed_q;

  // A press is accepted once GLITCH_CYCLES consecutive low samples are seen;
  // any high sample restarts the count and releases immediately.
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      low_cnt_q <= '0;
      pressed_q <= 1'b0;
    end else if (btn_n_s_i) begin
      low_cnt_q <= '0;
      pressed_q <= 1'b0;
    end else if (low_cnt_q == LAST) begin
      pressed_q <= 1'b1;
    end else begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign pressed_o = pressed_q;

endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog #(
  parameter int WD_CYCLES = 64
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic wdi_s_i,
  input  logic en_i,
  input  logic hold_i,
  output logic fire_o
);

  localparam int CW = (WD_CYCLES < 2) ? 1 : $clog2(WD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);

  logic          wdi_d_q;
  logic          toggle;
  logic [CW-1:0] cnt_q;
  logic          fire_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) wdi_d_q <= 1'b0;
    else          wdi_d_q <= wdi_s_i;
  end

  assign toggle = wdi_s_i ^ wdi_d_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (hold_i || !en_i || toggle) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q  <= '0;
      fire_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      fire_q <= 1'b0;
    end
  end

  assign fire_o = fire_q;

endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
  parameter int REC_CYCLES = 16
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic cause_i,
  output logic active_o
);

  localparam int CW = $clog2(REC_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(REC_CYCLES);

  logic [CW-1:0] left_q;
  logic          active_q;

  // Power-on starts asserted with the full interval loaded.
  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      left_q   <= FULL;
      active_q <= 1'b1;
    end else if (cause_i) begin
      left_q   <= FULL;
      active_q <= 1'b1;
    end else if (left_q > CW'(1)) begin
      left_q   <= left_q - 1'b1;
    end else begin
      left_q   <= '0;
      active_q <= 1'b0;
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/rsup_top.sv
module rsup_top #(
  parameter int                     TICK_HZ       = 50_000_000,
  parameter int                     REC_CYCLES    = TICK_HZ / 5,
  parameter int                     WD_CYCLES     = (TICK_HZ / 5) * 8,
  parameter int                     GLITCH_CYCLES = TICK_HZ / 4_000_000,
  parameter rsup_pkg::input_set_e   INPUT_SET     = rsup_pkg::IN_BOTH,
  parameter rsup_pkg::pad_mode_e    PAD_MODE      = rsup_pkg::PAD_PUSH_PULL
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic supply_ok_i,
  input  logic btn_ni,
  input  logic wdi_i,
  input  logic wd_en_i,
  output logic rst_no,
  output logic rst_o,
  output logic pad_oe_o
);

  import rsup_pkg::*;

  // Supply assumed bad, button released, watchdog input low at power-on.
  localparam logic [SYN_W-1:0] SYN_RST = 3'b010;

  logic [SYN_W-1:0] raw, syn;
  logic sup_s, btn_s, wdi_s;
  logic pressed, wd_fire, cause, act;

  assign raw[SYN_SUP] = supply_ok_i;
  assign raw[SYN_BTN] = btn_ni;
  assign raw[SYN_WDI] = wdi_i;

  rsup_sync #(.W(SYN_W), .RST_VAL(SYN_RST)) u_sync (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .d_i    (raw),
    .q_o    (syn)
  );

  assign sup_s = syn[SYN_SUP];
  assign btn_s = syn[SYN_BTN];
  assign wdi_s = syn[SYN_WDI];

  if (INPUT_SET != IN_WDI_ONLY) begin : g_btn
    rsup_btn_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_filt (
      .clk_i    (clk_i),
      .arst_ni  (arst_ni),
      .btn_n_s_i(btn_s),
      .pressed_o(pressed)
    );
  end else begin : g_no_btn
    assign pressed = 1'b0;
  end

  if (INPUT_SET != IN_BTN_ONLY) begin : g_wd
    rsup_wdog #(.WD_CYCLES(WD_CYCLES)) u_wdog (
      .clk_i  (clk_i),
      .arst_ni(arst_ni),
      .wdi_s_i(wdi_s),
      .en_i   (wd_en_i),
      .hold_i (act),
      .fire_o (wd_fire)
    );
  end else begin : g_no_wd
    assign wd_fire = 1'b0;
  end

  assign cause = !sup_s || pressed || wd_fire;

  rsup_stretch #(.REC_CYCLES(REC_CYCLES)) u_stretch (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .cause_i (cause),
    .active_o(act)
  );

  assign rst_o  = act;
  assign rst_no = !act;

  if (PAD_MODE == PAD_OPEN_DRAIN) begin : g_od
    assign pad_oe_o = act;
  end else begin : g_pp
    assign pad_oe_o = 1'b1;
  end

endmodule

// File: rtl/rsup_chk.sv
module rsup_chk #(
  parameter rsup_pkg::pad_mode_e PAD_MODE = rsup_pkg::PAD_PUSH_PULL
) (
  input logic clk_i,
  input logic arst_ni,
  input logic sup_s,
  input logic pressed,
  input logic wd_fire,
  input logic wd_en_i,
  input logic act,
  input logic rst_no,
  input logic rst_o,
  input logic pad_oe_o
);

  AST_SUPPLY_LOW_RESETS: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !sup_s |=> act); // R2

  AST_PRESS_RESETS: assert property (@(posedge clk_i) disable iff (!arst_ni)
    pressed |=> act); // R3

  AST_EXPIRY_RESETS: assert property (@(posedge clk_i) disable iff (!arst_ni)
    wd_fire |=> act); // R5

  AST_NO_FIRE_IN_RESET: assert property (@(posedge clk_i) disable iff (!arst_ni)
    act |=> !wd_fire); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!arst_ni)
    !wd_en_i |=> !wd_fire); // R9

  AST_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!arst_ni)
    rst_o != rst_no); // R10

  AST_PAD_FOLLOW: assert property (@(posedge clk_i) disable iff (!arst_ni)
    pad_oe_o == ((PAD_MODE == rsup_pkg::PAD_OPEN_DRAIN) ? rst_o : 1'b1)); // R11

endmodule

bind rsup_top rsup_chk #(.PAD_MODE(PAD_MODE)) u_chk (
  .clk_i   (clk_i),
  .arst_ni (arst_ni),
  .sup_s   (sup_s),
  .pressed (pressed),
  .wd_fire (wd_fire),
  .wd_en_i (wd_en_i),
  .act     (act),
  .rst_no  (rst_no),
  .rst_o   (rst_o),
  .pad_oe_o(pad_oe_o)
);

// File: tb/tb_rsup_top.sv
module tb_rsup_top;

  localparam int REC = 20;
  localparam int WD  = 40;
  localparam int G   = 4;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic sup = 1'b1, btn = 1'b1, wdi = 1'b0, wd_en = 1'b0;
  logic rst_n, rst, pad_oe;

  always #10 clk = ~clk; // 50 MHz

  rsup_top #(
    .REC_CYCLES(REC), .WD_CYCLES(WD), .GLITCH_CYCLES(G),
    .PAD_MODE(rsup_pkg::PAD_OPEN_DRAIN)
  ) dut (
    .clk_i(clk), .arst_ni(arst_n), .supply_ok_i(sup), .btn_ni(btn),
    .wdi_i(wdi), .wd_en_i(wd_en), .rst_no(rst_n), .rst_o(rst), .pad_oe_o(pad_oe)
  );

  typedef struct { int at; logic val; string tag; } exp_t;
  exp_t sb[$];
  exp_t it;
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic act_v, input logic exp_v, input string tag);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, cyc, act_v, exp_v);
    end
  endtask

  // Monitor: pops scoreboard items due in this cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      it = sb.pop_front();
      if (it.at < cyc) begin
        n_chk++; n_bad++;
        $display("FAIL %s missed slot %0d: actual=none expected=%b", it.tag, it.at, it.val);
      end else begin
        check(rst_n, it.val, it.tag);
        check(rst, !rst_n, "R10 complement");
        check(pad_oe, rst, "R11 open-drain enable");
      end
    end
  end

  task automatic push(input int base, input int k, input logic v, input string tag);
    exp_t e;
    e.at = base + k; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic push_range(input int base, input int k0, input int k1, input logic v, input string tag);
    for (int k = k0; k <= k1; k++) push(base, k, v, tag);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  task automatic press_btn(input int len, input bit wd_follow, input string tag);
    int b;
    b = cyc;
    btn = 1'b0;
    if (len >= G) begin
      push(b, 2 + G, 1'b1, tag);
      push(b, 3 + G, 1'b0, tag);
      push(b, 2 + len + REC, 1'b0, tag);
      push(b, 3 + len + REC, 1'b1, tag);
      if (wd_follow) begin
        push(b, 3 + len + REC + WD, 1'b1, "R7 count from zero after release");
        push(b, 4 + len + REC + WD, 1'b0, "R7 count from zero after release");
      end
    end else begin
      push_range(b, 1, len + REC + 6, 1'b1, tag);
    end
    repeat (len) @(negedge clk);
    btn = 1'b1;
    drain();
  endtask

  initial begin
    int b;
    repeat (3) @(negedge clk);
    check(rst_n, 1'b0, "R1 reset state rst_no");
    check(rst, 1'b1, "R1/R10 reset state rst_o");
    check(pad_oe, 1'b1, "R11 reset state pad");

    // R1: release of power-on reset
    b = cyc; arst_n = 1'b1;
    push(b, 1 + REC, 1'b0, "R1 recovery after power-on");
    push(b, 2 + REC, 1'b1, "R1 recovery after power-on");
    drain();

    // R2: supply loss and return
    b = cyc; sup = 1'b0;
    push(b, 2, 1'b1, "R2 supply drop latency");
    push(b, 3, 1'b0, "R2 supply drop latency");
    push_range(b, 4, 12, 1'b0, "R2 held while supply low");
    drain();
    b = cyc; sup = 1'b1;
    push(b, 1 + REC, 1'b0, "R2 recovery after supply");
    push(b, 2 + REC, 1'b1, "R2 recovery after supply");
    drain();

    // R3 / R4: push-button
    press_btn(8, 1'b0, "R3 long press");
    press_btn(G, 1'b0, "R3 press at glitch length");
    press_btn(G - 1, 1'b0, "R4 glitch ignored");
    press_btn(1, 1'b0, "R4 single-cycle glitch ignored");

    // R9: disabled watchdog stays quiet
    b = cyc;
    push_range(b, 1, 3 * WD, 1'b1, "R9 watchdog disabled");
    drain();

    // R5 / R8 / R7: expiry, its recovery, and the next expiry
    b = cyc; wd_en = 1'b1;
    push(b, WD, 1'b1, "R5 expiry timing");
    push(b, WD + 1, 1'b0, "R5 expiry timing");
    push(b, WD + REC, 1'b0, "R8 expiry recovery");
    push(b, WD + 1 + REC, 1'b1, "R8 expiry recovery");
    push(b, 2 * WD + 1 + REC, 1'b1, "R7 restart from zero");
    push(b, 2 * WD + 2 + REC, 1'b0, "R7 restart from zero");
    push(b, 2 * WD + 1 + 2 * REC, 1'b0, "R8 second recovery");
    push(b, 2 * WD + 2 + 2 * REC, 1'b1, "R8 second recovery");
    drain();
    wd_en = 1'b0;
    @(negedge clk);

    // R6: regular toggling keeps reset away, then stop
    b = cyc; wd_en = 1'b1;
    push_range(b, 1, 8 * (WD / 2) + 2, 1'b1, "R6 serviced by both edges");
    for (int i = 0; i < 8; i++) begin
      repeat (WD / 2) @(negedge clk);
      wdi = !wdi;
    end
    b = cyc;
    push(b, 3 + WD, 1'b1, "R5 expiry after last toggle");
    push(b, 4 + WD, 1'b0, "R5 expiry after last toggle");
    push(b, 3 + WD + REC, 1'b0, "R8 recovery");
    push(b, 4 + WD + REC, 1'b1, "R8 recovery");
    drain();

    // R6: one-cycle pulse services the watchdog
    b = cyc; wdi = !wdi;
    push(b, 4 + WD, 1'b1, "R6 one-cycle pulse");
    push(b, 5 + WD, 1'b0, "R6 one-cycle pulse");
    push(b, 4 + WD + REC, 1'b0, "R8 recovery");
    push(b, 5 + WD + REC, 1'b1, "R8 recovery");
    @(negedge clk);
    wdi = !wdi;
    drain();

    // R7: long reset does not let the watchdog count
    press_btn(3 * WD, 1'b1, "R3 long press with watchdog on");
    wd_en = 1'b0;
    repeat (REC + 5) @(negedge clk);
    check(rst_n, 1'b1, "R9 released after disable");

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule